// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

A single-cycle arithmetic and logic unit for a small 8-bit accumulator processor, paired with the processor's status register. An operation code, the accumulator operand and the memory operand go in. The result and the updated flag byte come out combinationally. The status register takes the updated flags on a clock edge, but only when the flag-write enable is high.

The unit covers the following operations:
- add with carry, and subtract with borrow (the adder fed the inverted operand);
- compare;
- AND, OR and XOR, plus a pass-through used for loads and transfers;
- bit test;
- the four shifts and rotates.

It also formats the status byte for a stack push, and reloads the flags from a byte pulled off the stack. Arithmetic is binary only: the decimal flag is stored, but it has no effect on the result.

Flag byte layout, used on every byte-wide flag port: bit 7 negative (N), bit 6 overflow (V), bit 5 always 1, bit 4 push-source marker, bit 3 decimal (D), bit 2 interrupt mask (I), bit 1 zero (Z), bit 0 carry (C). Unless stated otherwise, N is result bit 7 and Z is set when the result is zero.

Top module: `acc_alu`

## Requirements
- R1: After reset, flags_o reads 0x24: I is 1, bit 5 reads 1, and all other bits are 0.
- R2: Op 0 (add) gives result = a + m + C mod 256. C is the carry out. V is set when a and m have the same sign and the result's sign differs. N and Z follow the result.
- R3: Op 1 (subtract) gives result = a + ~m + C mod 256, so C = 1 means no borrow. V, N and Z follow the same rules as R2, applied to a and ~m.
- R4: Op 2 (compare) sets C when a >= m (unsigned), and sets N and Z from a - m mod 256. It leaves V unchanged, and result_o equals a.
- R5: Ops 3 (AND), 4 (OR), 5 (XOR) and 11 (pass m) give the named result. They update only N and Z and leave C and V unchanged.
- R6: Op 6 (bit test) sets V from m bit 6 and sets Z when (a AND m) is 0. N takes m bit 7, but reads 0 whenever Z is set. C is unchanged and result_o equals a.
- R7: Op 7 (shift left) shifts a zero into bit 0, and op 9 (rotate left) shifts the old C into bit 0. In both, the old a bit 7 goes to C.
- R8: Op 8 (shift right) shifts a zero into bit 7, and op 10 (rotate right) shifts the old C into bit 7. In both, the old a bit 0 goes to C.
- R9: The status register loads flags_next_o at a rising edge only when flag_we_i is 1. Otherwise flags_o holds.
- R10: When pull_i is 1, the register loads N, V, D, I, Z and C from pull_byte_i bits 7, 6, 3, 2, 1 and 0, and this takes priority over flag_we_i. Byte bits 5 and 4 are ignored, so flags_o bit 5 reads 1 and bit 4 reads 0.
- R11: push_byte_o is flags_o with bit 5 forced to 1 and bit 4 set to push_sw_i. push_sw_i is 1 for an instruction push and 0 for an interrupt push.
- R12: Op codes 12 to 15 give result_o = a and flags_next_o = flags_o.
- R13: D and I change only through a pull. No ALU operation alters them in flags_next_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Accumulator or register operand |
| m_i | input | 8 | Memory operand |
| flag_we_i | input | 1 | Commit flags_next_o to the status register |
| pull_i | input | 1 | Load the flags from pull_byte_i |
| pull_byte_i | input | 8 | Status byte pulled from the stack |
| push_sw_i | input | 1 | Push source: 1 = instruction, 0 = interrupt |
| result_o | output | 8 | Operation result |
| flags_next_o | output | 8 | Flags produced by the current operation |
| flags_o | output | 8 | Registered status byte |
| push_byte_o | output | 8 | Status byte formatted for a push |

## Verification
The bench builds the unit at its default width of 8 bits. At that width, the overflow, sign and carry cases can all be hit with hand-picked operands: 0x50 + 0x50, 0xFF + 0x01, and subtracting 0xB0 from 0x50. The same width lets compare be tried at the equal, below and above boundaries. The carry flag is preset through a pull before each group, so both values of the old carry reach the adder and the rotates.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADC  = 4'd0,
    OP_SBC  = 4'd1,
    OP_CMP  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_BIT  = 4'd6,
    OP_ASL  = 4'd7,
    OP_LSR  = 4'd8,
    OP_ROL  = 4'd9,
    OP_ROR  = 4'd10,
    OP_PASS = 4'd11
  } op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic d;
    logic i;
    logic z;
    logic c;
  } stat_t;

  localparam stat_t STAT_RESET = '{n: 1'b0, v: 1'b0, d: 1'b0, i: 1'b1, z: 1'b0, c: 1'b0};

  function automatic logic [7:0] stat_to_byte(stat_t s, logic b4);
    return {s.n, s.v, 1'b1, b4, s.d, s.i, s.z, s.c};
  endfunction

  function automatic stat_t byte_to_stat(logic [7:0] b);
    return '{n: b[7], v: b[6], d: b[3], i: b[2], z: b[1], c: b[0]};
  endfunction

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         co_o,
  output logic         ov_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  // subtraction reuses the adder on the complemented operand
  assign b_eff = inv_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
  assign sum_o = full[W-1:0];
  assign co_o  = full[W];
  assign ov_o  = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);

endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops #(
  parameter int W = 8
) (
  input  acc_alu_pkg::op_e op_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     m_i,
  output logic [W-1:0]     res_o
);
  import acc_alu_pkg::*;

  always_comb begin
    case (op_i)
      OP_AND, OP_BIT: res_o = a_i & m_i;
      OP_OR:          res_o = a_i | m_i;
      OP_XOR:         res_o = a_i ^ m_i;
      default:        res_o = m_i;
    endcase
  end

endmodule

// File: rtl/acc_alu_shifter.sv
module acc_alu_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  input  logic         left_i,
  input  logic         rot_i,
  output logic [W-1:0] res_o,
  output logic         co_o
);
  logic fill;

  assign fill = rot_i & cin_i;

  always_comb begin
    if (left_i) begin
      res_o = {a_i[W-2:0], fill};
      co_o  = a_i[W-1];
    end else begin
      res_o = {fill, a_i[W-1:1]};
      co_o  = a_i[0];
    end
  end

endmodule

// File: rtl/acc_alu_status.sv
module acc_alu_status (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  acc_alu_pkg::stat_t nxt_i,
  input  logic               pull_i,
  input  logic [7:0]         pull_byte_i,
  output acc_alu_pkg::stat_t q_o
);
  import acc_alu_pkg::*;

  stat_t q;
  logic  unused_pull_bits;

  assign unused_pull_bits = ^pull_byte_i[5:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= STAT_RESET;
    else if (pull_i) q <= byte_to_stat(pull_byte_i);
    else if (we_i)   q <= nxt_i;
  end

  assign q_o = q;

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !pull_i) |=> $stable(q));

  // R10
  pull_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_i |=> (q == $past({pull_byte_i[7:6], pull_byte_i[3:0]})));

  // R13
  di_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pull_i |=> $stable({q.d, q.i}));

endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] m_i,
  input  logic         flag_we_i,
  input  logic         pull_i,
  input  logic [7:0]   pull_byte_i,
  input  logic         push_sw_i,
  output logic [W-1:0] result_o,
  output logic [7:0]   flags_next_o,
  output logic [7:0]   flags_o,
  output logic [7:0]   push_byte_o
);
  import acc_alu_pkg::*;

  op_e          op;
  stat_t        st_q, st_d;
  logic [W-1:0] add_sum, log_res, sh_res, res;
  logic         add_co, add_ov, sh_co, is_sub, add_cin, sh_left, sh_rot;
  logic [W:0]   adc_ref;

  assign op      = op_e'(op_i);
  assign is_sub  = (op == OP_SBC) || (op == OP_CMP);
  assign add_cin = (op == OP_CMP) ? 1'b1 : st_q.c;
  assign sh_left = (op == OP_ASL) || (op == OP_ROL);
  assign sh_rot  = (op == OP_ROL) || (op == OP_ROR);

  acc_alu_adder #(.W(W)) u_add (
    .a_i   (a_i),
    .b_i   (m_i),
    .inv_i (is_sub),
    .cin_i (add_cin),
    .sum_o (add_sum),
    .co_o  (add_co),
    .ov_o  (add_ov)
  );

  acc_alu_bitops #(.W(W)) u_bitops (
    .op_i  (op),
    .a_i   (a_i),
    .m_i   (m_i),
    .res_o (log_res)
  );

  acc_alu_shifter #(.W(W)) u_shift (
    .a_i    (a_i),
    .cin_i  (st_q.c),
    .left_i (sh_left),
    .rot_i  (sh_rot),
    .res_o  (sh_res),
    .co_o   (sh_co)
  );

  always_comb begin
    res  = a_i;
    st_d = st_q;
    case (op)
      OP_ADC, OP_SBC: begin
        res    = add_sum;
        st_d.c = add_co;
        st_d.v = add_ov;
        st_d.n = add_sum[W-1];
        st_d.z = (add_sum == '0);
      end
      OP_CMP: begin
        st_d.c = add_co;
        st_d.n = add_sum[W-1];
        st_d.z = (add_sum == '0);
      end
      OP_AND, OP_OR, OP_XOR, OP_PASS: begin
        res    = log_res;
        st_d.n = log_res[W-1];
        st_d.z = (log_res == '0);
      end
      OP_BIT: begin
        st_d.z = (log_res == '0);
        st_d.n = m_i[W-1] & (log_res != '0);
        st_d.v = m_i[W-2];
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        res    = sh_res;
        st_d.c = sh_co;
        st_d.n = sh_res[W-1];
        st_d.z = (sh_res == '0);
      end
      default: ;
    endcase
  end

  acc_alu_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (flag_we_i),
    .nxt_i       (st_d),
    .pull_i      (pull_i),
    .pull_byte_i (pull_byte_i),
    .q_o         (st_q)
  );

  assign result_o     = res;
  assign flags_next_o = stat_to_byte(st_d, 1'b0);
  assign flags_o      = stat_to_byte(st_q, 1'b0);
  assign push_byte_o  = stat_to_byte(st_q, push_sw_i);

  assign adc_ref = {1'b0, a_i} + {1'b0, m_i} + {{W{1'b0}}, flags_o[0]};

  // R2
  adc_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && !pull_i && op_i == 4'd0) |=> (flags_o[0] == $past(adc_ref[W])));

  // R4
  cmp_v_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && !pull_i && op_i == 4'd2) |=> $stable(flags_o[6]));

endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] C_ADC = 4'd0, C_SBC = 4'd1, C_CMP = 4'd2, C_AND = 4'd3,
                         C_OR = 4'd4, C_XOR = 4'd5, C_BIT = 4'd6, C_ASL = 4'd7,
                         C_LSR = 4'd8, C_ROL = 4'd9, C_ROR = 4'd10, C_PASS = 4'd11;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] a_i = '0, m_i = '0, pull_byte_i = '0;
  logic       flag_we_i = 1'b0, pull_i = 1'b0, push_sw_i = 1'b0;
  logic [7:0] result_o, flags_next_o, flags_o, push_byte_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  acc_alu u_dut (
    .clk_i, .rst_ni, .op_i, .a_i, .m_i, .flag_we_i, .pull_i, .pull_byte_i,
    .push_sw_i, .result_o, .flags_next_o, .flags_o, .push_byte_o
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m,
                       input logic we, input logic pl, input logic [7:0] pb);
    @(negedge clk_i);
    op_i = op; a_i = a; m_i = m; flag_we_i = we; pull_i = pl; pull_byte_i = pb;
    #1;
  endtask

  task automatic commit();
    @(posedge clk_i);
    #1;
  endtask

  task automatic load_flags(input logic [7:0] pb);
    drive(4'd12, 8'h00, 8'h00, 1'b0, 1'b1, pb);
    commit();
    drive(4'd12, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic op_chk(input string req, input logic [3:0] op, input logic [7:0] a,
                        input logic [7:0] m, input logic [7:0] exp_res, input logic [7:0] exp_fl);
    drive(op, a, m, 1'b0, 1'b0, 8'h00);
    chk({req, " result"}, result_o, exp_res);
    chk({req, " flags"}, flags_next_o, exp_fl);
  endtask

  task automatic t_reset();
    push_sw_i = 1'b1; #1;
    chk("R1 reset flags", flags_o, 8'h24);
    chk("R11 reset push", push_byte_o, 8'h34);
  endtask

  task automatic t_adc();
    load_flags(8'h00);
    op_chk("R2 ovf", C_ADC, 8'h50, 8'h50, 8'hA0, 8'hE0);
    op_chk("R2 carry", C_ADC, 8'hFF, 8'h01, 8'h00, 8'h23);
    drive(C_ADC, 8'hFF, 8'h01, 1'b1, 1'b0, 8'h00);
    commit();
    chk("R2 commit", flags_o, 8'h23);
    op_chk("R2 cin", C_ADC, 8'h10, 8'h20, 8'h31, 8'h20);
  endtask

  task automatic t_sbc();
    load_flags(8'h01);
    op_chk("R3 borrow", C_SBC, 8'h50, 8'hF0, 8'h60, 8'h20);
    op_chk("R3 ovf", C_SBC, 8'h50, 8'hB0, 8'hA0, 8'hE0);
    load_flags(8'h00);
    op_chk("R3 cin0", C_SBC, 8'h05, 8'h03, 8'h01, 8'h21);
  endtask

  task automatic t_cmp();
    load_flags(8'h40);
    op_chk("R4 equal", C_CMP, 8'h10, 8'h10, 8'h10, 8'h63);
    op_chk("R4 below", C_CMP, 8'h10, 8'h20, 8'h10, 8'hE0);
    op_chk("R4 above", C_CMP, 8'h20, 8'h10, 8'h20, 8'h61);
  endtask

  task automatic t_logic();
    load_flags(8'h41);
    op_chk("R5 and", C_AND, 8'hF0, 8'h0F, 8'h00, 8'h63);
    op_chk("R5 or", C_OR, 8'h80, 8'h01, 8'h81, 8'hE1);
    op_chk("R5 xor", C_XOR, 8'hFF, 8'hFF, 8'h00, 8'h63);
    op_chk("R5 pass", C_PASS, 8'h00, 8'h80, 8'h80, 8'hE1);
  endtask

  task automatic t_bit();
    load_flags(8'h01);
    op_chk("R6 zero", C_BIT, 8'h01, 8'hC0, 8'h01, 8'h63);
    op_chk("R6 nv", C_BIT, 8'hFF, 8'hC0, 8'hFF, 8'hE1);
    op_chk("R6 plain", C_BIT, 8'h01, 8'h01, 8'h01, 8'h21);
  endtask

  task automatic t_shift();
    load_flags(8'h01);
    op_chk("R7 asl", C_ASL, 8'h81, 8'h00, 8'h02, 8'h21);
    op_chk("R7 rol c1", C_ROL, 8'h81, 8'h00, 8'h03, 8'h21);
    op_chk("R8 ror c1", C_ROR, 8'h02, 8'h00, 8'h81, 8'hA0);
    op_chk("R8 lsr", C_LSR, 8'h80, 8'h00, 8'h40, 8'h20);
    load_flags(8'h00);
    op_chk("R7 rol c0", C_ROL, 8'h80, 8'h00, 8'h00, 8'h23);
    op_chk("R8 lsr z", C_LSR, 8'h01, 8'h00, 8'h00, 8'h23);
  endtask

  task automatic t_hold();
    load_flags(8'h00);
    drive(C_ADC, 8'hFF, 8'h01, 1'b0, 1'b0, 8'h00);
    commit();
    chk("R9 hold", flags_o, 8'h20);
    drive(C_ADC, 8'hFF, 8'h01, 1'b1, 1'b0, 8'h00);
    commit();
    chk("R9 write", flags_o, 8'h23);
  endtask

  task automatic t_pull();
    load_flags(8'hFF);
    chk("R10 all ones", flags_o, 8'hEF);
    drive(C_ADC, 8'h00, 8'h00, 1'b1, 1'b1, 8'h30);
    commit();
    chk("R10 priority", flags_o, 8'h20);
    load_flags(8'h0C);
    op_chk("R13 keep di", C_ADC, 8'h80, 8'h80, 8'h00, 8'h6F);
  endtask

  task automatic t_push();
    load_flags(8'hFF);
    push_sw_i = 1'b1; #1;
    chk("R11 sw push", push_byte_o, 8'hFF);
    push_sw_i = 1'b0; #1;
    chk("R11 irq push", push_byte_o, 8'hEF);
    load_flags(8'h00);
    push_sw_i = 1'b1; #1;
    chk("R11 sw clear", push_byte_o, 8'h30);
  endtask

  task automatic t_undef();
    load_flags(8'hC3);
    for (int k = 12; k < 16; k++) begin
      drive(4'(k), 8'h5A, 8'hFF, 1'b0, 1'b0, 8'h00);
      chk("R12 result", result_o, 8'h5A);
      chk("R12 flags", flags_next_o, flags_o);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_adc();
    t_sbc();
    t_cmp();
    t_logic();
    t_bit();
    t_shift();
    t_hold();
    t_pull();
    t_push();
    t_undef();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule